// File: doc/BRIEF.md
# Buck Switch Pulse Timing Controller

This block produces the gate-enable level for the power switch of a buck converter. Each on-time ends when an internal cycle counter reaches the smaller of two on-time limit words, one from the power regulation loop and one from the current-limit loop. It ends sooner if a digitised over-current flag asserts after a leading-edge blanking window. Each off-time ends on a falling edge of the digitised zero-crossing flag, which gives critical conduction. If no such edge arrives within a maximum off-time, the block starts the next pulse anyway, which gives continuous conduction.

A disable request, which the surrounding logic raises for a sense over-voltage or for a limit word below its floor, holds the switch off and clears every phase counter. Two status levels record what ended the latest on-time and the latest off-time. Everything is counted in clock cycles. The blanking length and the maximum off-time are parameters. The limit words are inputs.

Top module: `buck_pulse_ctrl`

## Requirements
- R1: With no over-current, `gate_o` stays high for exactly min(`pwr_lim_i`, `cur_lim_i`) cycles. A minimum of 0 counts as 1.
- R2: When `ocp_i` is high at a rising edge after the blanking window of an on-time, `gate_o` is low from that edge on and `on_end_ocp_o` becomes 1. An on-time ended by the limit sets it to 0, and an over-current at the limit cycle reports 1.
- R3: During the first `BLANK_CYC` cycles of every on-time, `ocp_i` has no effect on `gate_o`.
- R4: In an off-time, once `zx_i` has been sampled high, the first edge that samples it low starts a new on-time at that edge and sets `off_end_tmo_o` to 0.
- R5: Without such a falling edge, an off-time lasts exactly `TOFF_MAX` cycles. The next on-time then starts and `off_end_tmo_o` becomes 1.
- R6: From the edge that samples `off_req_i` high, `gate_o` is low and stays low for as long as the request is held, whatever `ocp_i` and `zx_i` do.
- R7: At the first edge that samples `off_req_i` low again, a new on-time starts. It has the full R1 length, because the on-time, blanking and off-time counters restart from zero.
- R8: While `rst_n` is low, `gate_o`, `on_end_ocp_o` and `off_end_tmo_o` are 0 at every rising edge.
- R9: `on_end_ocp_o` changes only at the edge where an on-time ends in an off-time. `off_end_tmo_o` changes only at the edge where an off-time ends in an on-time. A disable leaves both unchanged.
- R10: A `zx_i` that is low at turn-off does not end the off-time until it has risen and fallen. A `zx_i` held at one level ends the off-time only by timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all timing is counted in its cycles |
| rst_n | input | 1 | Synchronous active-low reset |
| ocp_i | input | 1 | Over-current comparator flag, already synchronised |
| zx_i | input | 1 | Zero-crossing comparator flag, already synchronised |
| off_req_i | input | 1 | Disable request; keeps the switch off |
| pwr_lim_i | input | RAMP_W | On-time limit from the power loop, in cycles |
| cur_lim_i | input | RAMP_W | On-time limit from the current-limit loop, in cycles |
| gate_o | output | 1 | Registered switch gate-enable level |
| on_end_ocp_o | output | 1 | 1: last on-time ended by over-current; 0: by limit |
| off_end_tmo_o | output | 1 | 1: last off-time ended by timeout; 0: by zero-crossing |

## Verification
The on-time properties assume that the two limit words stay constant for the whole of an on-time, because the checker's own pulse counter is compared against their current minimum. The off-time timeout property assumes that a low gate outside a disable is always an off-phase or the one cycle that follows a release. The stimulus changes limits only while the block is held disabled, and it drives every flag half a cycle away from the sampling edge. Comparator flags therefore never change at the same time the design samples them.

// File: rtl/buck_pulse_pkg.sv
// Shared phase encoding for the buck pulse timing controller.
package buck_pulse_pkg;
    typedef enum logic [1:0] {
        PH_HOLD = 2'd0,   // disabled, switch off
        PH_ON   = 2'd1,   // switch conducting
        PH_OFF  = 2'd2    // inductor discharging
    } phase_t;
endpackage

// File: rtl/buck_ontime_ramp.sv
// On-time ramp: counts cycles of the current on-time and flags the cycle
// that reaches the smaller of two limit words.
// Assumes: step is high only while the on-phase continues into the next cycle.
module buck_ontime_ramp #(
    parameter int RAMP_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic [RAMP_W-1:0] lim_a,
    input  logic [RAMP_W-1:0] lim_b,
    output logic              lim_hit
);
    logic [RAMP_W-1:0] ramp_q;
    logic [RAMP_W-1:0] eff_lim;

    // Lower limit always governs the on-time
    always_comb eff_lim = (lim_a < lim_b) ? lim_a : lim_b;

    // Hit when this cycle is the last one the limit allows
    always_comb lim_hit = ({1'b0, ramp_q} + {{RAMP_W{1'b0}}, 1'b1}) >= {1'b0, eff_lim};

    // Ramp advances while the phase continues, otherwise returns to zero
    always_ff @(posedge clk) begin
        if (!rst_n)    ramp_q <= '0;
        else if (step) ramp_q <= ramp_q + 1'b1;
        else           ramp_q <= '0;
    end
endmodule

// File: rtl/buck_blank_timer.sv
// Leading-edge blanking: reports when the on-time has run long enough
// for the over-current flag to be trusted.
// Assumes: step follows the same rule as the ramp counter.
module buck_blank_timer #(
    parameter int BLANK_CYC = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    output logic open_o
);
    localparam int BW = $clog2(BLANK_CYC + 1) + 1;
    localparam logic [BW-1:0] LAST = BW'(BLANK_CYC);

    logic [BW-1:0] cnt_q;

    // Window opens once the count reaches the blanking length
    always_comb open_o = (cnt_q == LAST);

    // Count up to the window length and saturate there
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (!step)  cnt_q <= '0;
        else if (!open_o) cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/buck_off_timer.sv
// Off-phase timer: maximum off-time counter plus a zero-crossing detector
// that needs the flag to be seen high before a low can end the phase.
// Assumes: step is high only while the off-phase continues.
module buck_off_timer #(
    parameter int TOFF_MAX = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    input  logic zx_i,
    output logic tmo_o,
    output logic zx_fall_o
);
    localparam int CW = $clog2(TOFF_MAX) + 1;
    localparam logic [CW-1:0] LAST = CW'(TOFF_MAX - 1);

    logic [CW-1:0] cnt_q;
    logic          armed_q;

    // Timeout on the last allowed off cycle
    always_comb tmo_o = (cnt_q == LAST);

    // A low sample after an armed high is the falling edge
    always_comb zx_fall_o = armed_q && !zx_i;

    // Off-time count and arming, both cleared outside the phase
    always_ff @(posedge clk) begin
        if (!rst_n || !step) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
        end else begin
            cnt_q   <= cnt_q + 1'b1;
            armed_q <= armed_q | zx_i;
        end
    end
endmodule

// File: rtl/buck_pulse_ctrl.sv
// Buck switch pulse timing controller. Sequences hold, on and off phases,
// drives a registered gate level and records what ended each phase.
// Assumes: comparator flags are synchronous to clk; limits held steady
// during an on-time.
module buck_pulse_ctrl
    import buck_pulse_pkg::*;
#(
    parameter int RAMP_W    = 10,
    parameter int BLANK_CYC = 30,
    parameter int TOFF_MAX  = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ocp_i,
    input  logic              zx_i,
    input  logic              off_req_i,
    input  logic [RAMP_W-1:0] pwr_lim_i,
    input  logic [RAMP_W-1:0] cur_lim_i,
    output logic              gate_o,
    output logic              on_end_ocp_o,
    output logic              off_end_tmo_o
);
    phase_t ph_q, ph_d;
    logic   lim_hit, blank_open, ocp_hit, tmo, zx_fall;
    logic   on_step, off_step;

    // Counters run only while their phase continues
    always_comb on_step  = (ph_q == PH_ON)  && (ph_d == PH_ON);
    always_comb off_step = (ph_q == PH_OFF) && (ph_d == PH_OFF);
    always_comb ocp_hit  = ocp_i && blank_open;

    buck_ontime_ramp #(.RAMP_W(RAMP_W)) u_ramp (
        .clk(clk), .rst_n(rst_n), .step(on_step),
        .lim_a(pwr_lim_i), .lim_b(cur_lim_i), .lim_hit(lim_hit)
    );

    buck_blank_timer #(.BLANK_CYC(BLANK_CYC)) u_blank (
        .clk(clk), .rst_n(rst_n), .step(on_step), .open_o(blank_open)
    );

    buck_off_timer #(.TOFF_MAX(TOFF_MAX)) u_off (
        .clk(clk), .rst_n(rst_n), .step(off_step), .zx_i(zx_i),
        .tmo_o(tmo), .zx_fall_o(zx_fall)
    );

    // Next phase: disable wins, then the end conditions of each phase
    always_comb begin
        ph_d = ph_q;
        if (off_req_i) begin
            ph_d = PH_HOLD;
        end else begin
            case (ph_q)
                PH_HOLD: ph_d = PH_ON;
                PH_ON:   if (ocp_hit || lim_hit) ph_d = PH_OFF;
                PH_OFF:  if (zx_fall || tmo)     ph_d = PH_ON;
                default: ph_d = PH_HOLD;
            endcase
        end
    end

    // Phase, registered gate and end-cause status
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q          <= PH_HOLD;
            gate_o        <= 1'b0;
            on_end_ocp_o  <= 1'b0;
            off_end_tmo_o <= 1'b0;
        end else begin
            ph_q   <= ph_d;
            gate_o <= (ph_d == PH_ON);
            if (ph_q == PH_ON && ph_d == PH_OFF) on_end_ocp_o  <= ocp_hit;
            if (ph_q == PH_OFF && ph_d == PH_ON) off_end_tmo_o <= !zx_fall;
        end
    end
endmodule

// File: rtl/buck_pulse_ctrl_chk.sv
// Property checker for buck_pulse_ctrl, attached by bind. It keeps its own
// counts of high and low gate cycles, derived only from the ports.
module buck_pulse_ctrl_chk #(
    parameter int RAMP_W    = 10,
    parameter int BLANK_CYC = 30,
    parameter int TOFF_MAX  = 200
) (
    input logic              clk,
    input logic              rst_n,
    input logic              off_req_i,
    input logic [RAMP_W-1:0] pwr_lim_i,
    input logic [RAMP_W-1:0] cur_lim_i,
    input logic              gate_o,
    input logic              on_end_ocp_o,
    input logic              off_end_tmo_o
);
    localparam int HW = RAMP_W + 1;
    localparam int LW = $clog2(TOFF_MAX) + 2;

    logic [HW-1:0] hi_cnt;
    logic [LW-1:0] lo_cnt;
    logic [HW-1:0] min_lim;

    // Smaller limit, widened for comparison
    always_comb min_lim = (pwr_lim_i < cur_lim_i) ? {1'b0, pwr_lim_i} : {1'b0, cur_lim_i};

    // Index of the current high or low cycle, saturating
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cnt <= '0;
            lo_cnt <= '0;
        end else begin
            hi_cnt <= gate_o ? ((&hi_cnt) ? hi_cnt : hi_cnt + 1'b1) : '0;
            lo_cnt <= gate_o ? '0 : ((&lo_cnt) ? lo_cnt : lo_cnt + 1'b1);
        end
    end

    // R8: outputs are cleared by reset
    p_reset_clear_r8: assert property (@(posedge clk)
        !rst_n |=> (!gate_o && !on_end_ocp_o && !off_end_tmo_o));

    // R6: a disable request forces the gate low at the next edge
    p_disable_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        off_req_i |=> !gate_o);

    // R1: the on-time never outlasts the smaller limit
    p_ontime_max_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_o && (hi_cnt + 1'b1 >= min_lim)) |=> !gate_o);

    // R3: inside the blanking window only the limit or a disable ends the pulse
    p_blank_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_o && hi_cnt < HW'(BLANK_CYC) && (hi_cnt + 1'b1 < min_lim) && !off_req_i)
        |=> gate_o);

    // R5: a low gate never lasts beyond the maximum off-time unless disabled
    p_off_timeout_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate_o && lo_cnt >= LW'(TOFF_MAX - 1) && !off_req_i) |=> gate_o);

    // R9: on-time cause changes only when the gate falls
    p_oncause_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(gate_o) |-> $stable(on_end_ocp_o));

    // R9: off-time cause changes only when the gate rises
    p_offcause_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(gate_o) |-> $stable(off_end_tmo_o));
endmodule

bind buck_pulse_ctrl buck_pulse_ctrl_chk #(
    .RAMP_W(RAMP_W), .BLANK_CYC(BLANK_CYC), .TOFF_MAX(TOFF_MAX)
) u_chk (
    .clk(clk), .rst_n(rst_n), .off_req_i(off_req_i),
    .pwr_lim_i(pwr_lim_i), .cur_lim_i(cur_lim_i), .gate_o(gate_o),
    .on_end_ocp_o(on_end_ocp_o), .off_end_tmo_o(off_end_tmo_o)
);

// File: tb/buck_pulse_ctrl_test.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, inputs driven and outputs sampled
// on the falling clock edge.
module buck_pulse_ctrl_test;
    localparam int RAMP_W    = 10;
    localparam int BLANK_CYC = 30;
    localparam int TOFF_MAX  = 200;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ocp = 1'b0, zx = 1'b0, off_req = 1'b1;
    logic [RAMP_W-1:0] pwr_lim = 10'd20, cur_lim = 10'd20;
    logic gate, c_ocp, c_tmo;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;   // 250 MHz

    buck_pulse_ctrl #(.RAMP_W(RAMP_W), .BLANK_CYC(BLANK_CYC), .TOFF_MAX(TOFF_MAX)) uut (
        .clk(clk), .rst_n(rst_n), .ocp_i(ocp), .zx_i(zx), .off_req_i(off_req),
        .pwr_lim_i(pwr_lim), .cur_lim_i(cur_lim), .gate_o(gate),
        .on_end_ocp_o(c_ocp), .off_end_tmo_o(c_tmo)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Advance on falling edges until the gate shows the wanted level
    task automatic await_gate(input logic lvl);
        for (int i = 0; i < 1000 && gate !== lvl; i++) @(negedge clk);
    endtask

    // Count consecutive falling-edge samples at the current gate level
    task automatic width(input logic lvl, output int n);
        n = 0;
        for (int i = 0; i < 2000 && gate === lvl; i++) begin
            n++;
            @(negedge clk);
        end
    endtask

    // Park disabled, load limits, release; returns at on-time cycle 0
    task automatic start_fresh(input int p, input int c);
        @(negedge clk);
        off_req = 1'b1; ocp = 1'b0; zx = 1'b0;
        pwr_lim = RAMP_W'(p); cur_lim = RAMP_W'(c);
        repeat (2) @(negedge clk);
        off_req = 1'b0;
        @(negedge clk);
        await_gate(1'b1);
    endtask

    task automatic t_reset();
        repeat (4) @(negedge clk);
        chk("R8 gate in reset", gate, 0);
        chk("R8 ocp cause in reset", c_ocp, 0);
        chk("R8 tmo cause in reset", c_tmo, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R6 held off after reset", gate, 0);
    endtask

    task automatic t_ramp_limits();
        int n;
        start_fresh(20, 50);
        width(1'b1, n);
        chk("R1 power limit lower", n, 20);
        chk("R2 cause is limit", c_ocp, 0);
        width(1'b0, n);
        chk("R10 low zx no retrigger, R5 timeout width", n, TOFF_MAX);
        chk("R5 cause is timeout", c_tmo, 1);
        start_fresh(60, 15);
        width(1'b1, n);
        chk("R1 current limit lower", n, 15);
    endtask

    task automatic t_overcurrent();
        int n;
        start_fresh(100, 100);
        repeat (40) @(negedge clk);
        ocp = 1'b1;
        @(negedge clk);
        chk("R2 gate low after ocp", gate, 0);
        chk("R2 cause is ocp", c_ocp, 1);
        ocp = 1'b0;
    endtask

    task automatic t_blanking();
        int n;
        start_fresh(50, 50);
        ocp = 1'b1;
        repeat (BLANK_CYC) @(negedge clk);
        ocp = 1'b0;
        width(1'b1, n);
        chk("R3 ocp in blanking ignored", n + BLANK_CYC, 50);
        chk("R3 cause stays limit", c_ocp, 0);
    endtask

    task automatic t_zero_cross();
        int n;
        start_fresh(10, 10);
        width(1'b1, n);
        repeat (5) @(negedge clk);
        zx = 1'b1;
        repeat (5) @(negedge clk);
        chk("R10 high zx alone no restart", gate, 0);
        zx = 1'b0;
        @(negedge clk);
        chk("R4 restart on zx fall", gate, 1);
        chk("R4 cause is zero crossing", c_tmo, 0);
        // flag already high at turn-off
        start_fresh(10, 10);
        repeat (5) @(negedge clk);
        zx = 1'b1;
        width(1'b1, n);
        repeat (3) @(negedge clk);
        zx = 1'b0;
        @(negedge clk);
        chk("R4 zx high at turn-off then fall", gate, 1);
        // flag held high through the off-time
        start_fresh(10, 10);
        zx = 1'b1;
        width(1'b1, n);
        width(1'b0, n);
        chk("R10 held-high zx times out", n, TOFF_MAX);
        chk("R5 cause is timeout", c_tmo, 1);
        zx = 1'b0;
    endtask

    task automatic t_disable();
        int n, bad;
        logic so, st;
        start_fresh(30, 30);
        repeat (10) @(negedge clk);
        so = c_ocp; st = c_tmo;
        off_req = 1'b1;
        @(negedge clk);
        chk("R6 gate low on disable", gate, 0);
        bad = 0;
        for (int i = 0; i < 20; i++) begin
            zx = i[0]; ocp = i[1];
            @(negedge clk);
            if (gate !== 1'b0) bad++;
        end
        chk("R6 gate stays low while disabled", bad, 0);
        chk("R9 ocp cause kept", c_ocp, so);
        chk("R9 tmo cause kept", c_tmo, st);
        zx = 1'b0; ocp = 1'b0;
        off_req = 1'b0;
        @(negedge clk);
        chk("R7 restart after release", gate, 1);
        width(1'b1, n);
        chk("R7 full on-time after disable", n, 30);
        repeat (50) @(negedge clk);
        off_req = 1'b1;
        @(negedge clk);
        off_req = 1'b0;
        @(negedge clk);
        chk("R7 restart after disable in off-time", gate, 1);
        width(1'b1, n);
        chk("R7 full on-time after off disable", n, 30);
    endtask

    initial begin
        t_reset();
        t_ramp_limits();
        t_overcurrent();
        t_blanking();
        t_zero_cross();
        t_disable();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #400000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule